// File: doc/BRIEF.md
# Lock-protected system control registers

This block is a bank of board-level control and status registers on a simple 32-bit bus with a 12-bit byte address, which covers a 4 KB window. Software reads an identification word and a processor identifier, drives a small LED register, and keeps two scratch configuration words. It has a volatile flag register and a non-volatile flag register, each with one address that sets bits and another that clears them. A free-running tick counter that advances once every `TICK_DIV` clocks can also be read.

A lock register guards the reset-control register. Only the key value 0xA05F unlocks it. Writes to reset-control land only while the block is unlocked. The board-variant field, bits 27:16 of the identification word, decides which reset-control bit raises a system-reset request. On variants without that function, the register reads as zero and ignores writes. The request leaves the block as a one-cycle pulse.

Reads are combinational from the address, so read data is valid in the same cycle as the address. Writes take effect at the rising edge where `wr_en_i` is high.

Top module: `sysctl_regbank`

## Requirements
- R1: Offset 0x00 returns `ID_WORD`, 0x84 returns `PROC_ID`, 0x44 always returns 1 and 0x88 always returns 0xFF000000. The board variant is `ID_WORD[27:16]`.
- R2: A write to the lock register at 0x20 whose low 16 data bits equal 0xA05F stores 0xA05F, and the block is then unlocked. Any other value is stored from the low 16 bits with bit 15 forced to 0, which leaves the block locked. The register reads back zero-extended.
- R3: A write to reset-control at 0x40 is stored in full only while the lock register holds 0xA05F. Otherwise the write is ignored.
- R4: The trigger bit is bit 8 on variant 0x100 and bit 2 on variants 0x178 and 0x182. An accepted reset-control write with the trigger bit set drives `sys_rst_req_o` high for exactly the one cycle after the write.
- R5: On every other variant, reset-control reads as 0, ignores writes and never raises `sys_rst_req_o`.
- R6: The volatile flags read at 0x30. A write to 0x30 ORs the data into them, and a write to 0x34 clears the bits that are set in the data.
- R7: The non-volatile flags read at 0x38. A write to 0x38 sets bits and a write to 0x3C clears them. A block reset leaves them unchanged.
- R8: Reset clears the LED, lock, both configuration words, the volatile flags, reset-control, the tick counter and `sys_rst_req_o`.
- R9: The LED register at 0x08 holds the low `LED_W` data bits, drives `led_o` and reads back zero-extended. The configuration words at 0x28 and 0x2C are full 32-bit read/write.
- R10: The counter at 0x5C is 0 during reset. It then rises by exactly 1 every `TICK_DIV` clock cycles.
- R11: Offsets with no register read as 0. Writes to those offsets, to read-only offsets, or to any address whose two low bits are not zero change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 12 | Byte address inside the 4 KB window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| led_o | output | LED_W | LED register contents |
| sys_rst_req_o | output | 1 | One-cycle system-reset request |

## Verification
Read data depends only on the address and the stored state. The bench therefore drives the address at a falling edge and samples `rdata_o` 1 ns later, within the same cycle. A register written at a rising edge is read back no earlier than the falling edge that follows that edge. The reset request is due in the cycle right after the accepted write edge: it is sampled high at the falling edge after the write, and low again one falling edge later. The tick counter is checked by difference only, with two reads 12 falling edges apart under a divide of 3, so the expected step of 4 does not depend on divider phase.

// File: rtl/sysctl_pkg.sv
// sysctl_pkg: shared constants for the system control register bank.
// Assumes a 32-bit data bus and word-aligned register offsets.
package sysctl_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int WIDX_W = ADDR_W - 2;

    localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

    // Word indices (byte offset / 4) that software relies on.
    localparam logic [WIDX_W-1:0] W_ID        = 10'h000; // 0x00
    localparam logic [WIDX_W-1:0] W_LED       = 10'h002; // 0x08
    localparam logic [WIDX_W-1:0] W_LOCK      = 10'h008; // 0x20
    localparam logic [WIDX_W-1:0] W_CFG0      = 10'h00A; // 0x28
    localparam logic [WIDX_W-1:0] W_CFG1      = 10'h00B; // 0x2C
    localparam logic [WIDX_W-1:0] W_VFLG_SET  = 10'h00C; // 0x30
    localparam logic [WIDX_W-1:0] W_VFLG_CLR  = 10'h00D; // 0x34
    localparam logic [WIDX_W-1:0] W_NVFLG_SET = 10'h00E; // 0x38
    localparam logic [WIDX_W-1:0] W_NVFLG_CLR = 10'h00F; // 0x3C
    localparam logic [WIDX_W-1:0] W_RSTCTL    = 10'h010; // 0x40
    localparam logic [WIDX_W-1:0] W_CONST_ONE = 10'h011; // 0x44
    localparam logic [WIDX_W-1:0] W_TICK      = 10'h017; // 0x5C
    localparam logic [WIDX_W-1:0] W_PROC0     = 10'h021; // 0x84
    localparam logic [WIDX_W-1:0] W_PROC1     = 10'h022; // 0x88

    localparam logic [DATA_W-1:0] PROC1_VALUE = 32'hFF00_0000;

    // Board-variant codes that own a reset trigger.
    localparam logic [11:0] VAR_OLDEST = 12'h100;
    localparam logic [11:0] VAR_LATE_A = 12'h178;
    localparam logic [11:0] VAR_LATE_B = 12'h182;

    typedef enum logic [1:0] {
        TRIG_NONE = 2'd0,
        TRIG_BIT8 = 2'd1,
        TRIG_BIT2 = 2'd2
    } trig_mode_e;

    // Maps a board variant onto its reset-trigger behaviour.
    function automatic trig_mode_e trig_mode_of(input logic [11:0] variant);
        if (variant == VAR_OLDEST) begin
            return TRIG_BIT8;
        end else if (variant == VAR_LATE_A || variant == VAR_LATE_B) begin
            return TRIG_BIT2;
        end
        return TRIG_NONE;
    endfunction

endpackage

// File: rtl/sysctl_lock.sv
// sysctl_lock: 16-bit lock register with a magic unlock key.
// Stores the key unchanged; any other value is stored with bit 15 cleared,
// which can never equal the key (key bit 15 is 1). Assumes KEY[15] == 1.
module sysctl_lock #(
    parameter logic [15:0] KEY = 16'hA05F
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] lock_o,
    output logic        unlocked_o
);

    logic [15:0] lock_q;

    // Lock storage: key kept as is, other values stored with bit 15 dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else if (wr_i) begin
            lock_q <= (wdata_i == KEY) ? wdata_i : {1'b0, wdata_i[14:0]};
        end
    end

    assign lock_o     = lock_q;
    assign unlocked_o = (lock_q == KEY);

    // R2: a wrong value always leaves the block locked.
    p_wrong_key_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i != KEY) |=> !unlocked_o);

    // R2: the key always unlocks.
    p_key_unlocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i == KEY) |=> unlocked_o);

endmodule

// File: rtl/sysctl_flagreg.sv
// sysctl_flagreg: flag register with separate set and clear strobes.
// KEEP_ON_RESET selects a variant whose contents survive the block reset.
// Assumes set and clear are never asserted together (distinct addresses).
module sysctl_flagreg #(
    parameter int W             = 32,
    parameter bit KEEP_ON_RESET = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_i,
    input  logic         clr_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] flags_o
);

    logic [W-1:0] flags_q;

    generate
        if (KEEP_ON_RESET) begin : g_keep
            // Non-volatile flags: set/clear only, untouched by reset.
            always_ff @(posedge clk) begin
                if (set_i) begin
                    flags_q <= flags_q | data_i;
                end else if (clr_i) begin
                    flags_q <= flags_q & ~data_i;
                end
            end
        end else begin : g_volatile
            // Volatile flags: cleared by reset, otherwise set/clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flags_q <= '0;
                end else if (set_i) begin
                    flags_q <= flags_q | data_i;
                end else if (clr_i) begin
                    flags_q <= flags_q & ~data_i;
                end
            end
        end
    endgenerate

    assign flags_o = flags_q;

    // R6/R7: after a set, every requested bit reads as one.
    p_set_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> ((flags_o & $past(data_i)) == $past(data_i)));

    // R6/R7: after a clear, every requested bit reads as zero.
    p_clear_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> ((flags_o & $past(data_i)) == '0));

endmodule

// File: rtl/sysctl_tick.sv
// sysctl_tick: free-running counter advanced by a clock-enable divider.
// The counter steps once every DIV cycles; DIV == 1 steps every cycle.
module sysctl_tick #(
    parameter int DIV = 2,
    parameter int CW  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] count_o
);

    localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;

    logic          step;
    logic [CW-1:0] count_q;

    generate
        if (DIV > 1) begin : g_div
            logic [DCW-1:0] div_q;
            // Prescaler: wraps at DIV-1 and raises the step enable there.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (div_q == DCW'(DIV - 1)) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
            assign step = (div_q == DCW'(DIV - 1));
        end else begin : g_nodiv
            assign step = 1'b1;
        end
    endgenerate

    // Tick counter: advances on each enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (step) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

    // R10: the counter only ever moves forward by one.
    p_tick_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |-> (count_o == $past(count_o) + 1'b1));

endmodule

// File: rtl/sysctl_regbank.sv
// sysctl_regbank: memory-mapped system control registers with a
// lock-protected reset-control register. The reset-trigger behaviour is
// resolved at elaboration from ID_WORD[27:16]. Reads are combinational;
// writes land on the rising edge where wr_en_i is high. Addresses with
// nonzero low bits decode to nothing.
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter logic [31:0] ID_WORD  = 32'h0100_0000,
    parameter logic [31:0] PROC_ID  = 32'h0000_0000,
    parameter int          LED_W    = 8,
    parameter int          TICK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [LED_W-1:0]  led_o,
    output logic              sys_rst_req_o
);

    localparam trig_mode_e MODE = trig_mode_of(ID_WORD[27:16]);

    logic              aligned;
    logic [WIDX_W-1:0] widx;
    logic              wr_ok;
    logic [15:0]       lock_val;
    logic              unlocked;
    logic [LED_W-1:0]  led_q;
    logic [DATA_W-1:0] cfg0_q;
    logic [DATA_W-1:0] cfg1_q;
    logic [DATA_W-1:0] vflags;
    logic [DATA_W-1:0] nvflags;
    logic [DATA_W-1:0] rstctl_val;
    logic [DATA_W-1:0] tick_val;
    logic              req_d;
    logic              req_q;

    assign aligned = (addr_i[1:0] == 2'b00);
    assign widx    = addr_i[ADDR_W-1:2];
    assign wr_ok   = wr_en_i && aligned;

    sysctl_lock #(.KEY(UNLOCK_KEY)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_ok && widx == W_LOCK),
        .wdata_i    (wdata_i[15:0]),
        .lock_o     (lock_val),
        .unlocked_o (unlocked)
    );

    sysctl_flagreg #(.W(DATA_W), .KEEP_ON_RESET(1'b0)) u_vflags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (wr_ok && widx == W_VFLG_SET),
        .clr_i   (wr_ok && widx == W_VFLG_CLR),
        .data_i  (wdata_i),
        .flags_o (vflags)
    );

    sysctl_flagreg #(.W(DATA_W), .KEEP_ON_RESET(1'b1)) u_nvflags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (wr_ok && widx == W_NVFLG_SET),
        .clr_i   (wr_ok && widx == W_NVFLG_CLR),
        .data_i  (wdata_i),
        .flags_o (nvflags)
    );

    sysctl_tick #(.DIV(TICK_DIV), .CW(DATA_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (tick_val)
    );

    // Plain read/write storage: LED and the two configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q  <= '0;
            cfg0_q <= '0;
            cfg1_q <= '0;
        end else if (wr_ok) begin
            if (widx == W_LED)  led_q  <= wdata_i[LED_W-1:0];
            if (widx == W_CFG0) cfg0_q <= wdata_i;
            if (widx == W_CFG1) cfg1_q <= wdata_i;
        end
    end

    generate
        if (MODE == TRIG_NONE) begin : g_rstctl_absent
            assign rstctl_val = '0;
            assign req_d      = 1'b0;
        end else begin : g_rstctl
            localparam int TRIG_BIT = (MODE == TRIG_BIT8) ? 8 : 2;
            logic              accept;
            logic [DATA_W-1:0] rstctl_q;

            assign accept = wr_ok && (widx == W_RSTCTL) && unlocked;

            // Reset-control storage: updated only by an unlocked write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rstctl_q <= '0;
                end else if (accept) begin
                    rstctl_q <= wdata_i;
                end
            end

            assign rstctl_val = rstctl_q;
            assign req_d      = accept && wdata_i[TRIG_BIT];

            // R3: a locked write leaves reset-control unchanged.
            p_rstctl_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_ok && widx == W_RSTCTL && !unlocked) |=> $stable(rstctl_q));
        end
    endgenerate

    // Reset request: one registered cycle after the triggering write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_d;
        end
    end

    assign sys_rst_req_o = req_q;
    assign led_o         = led_q;

    // Read return: combinational select on the word index.
    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            case (widx)
                W_ID:        rdata_o = ID_WORD;
                W_LED:       rdata_o = DATA_W'(led_q);
                W_LOCK:      rdata_o = DATA_W'(lock_val);
                W_CFG0:      rdata_o = cfg0_q;
                W_CFG1:      rdata_o = cfg1_q;
                W_VFLG_SET:  rdata_o = vflags;
                W_NVFLG_SET: rdata_o = nvflags;
                W_RSTCTL:    rdata_o = rstctl_val;
                W_CONST_ONE: rdata_o = DATA_W'(1);
                W_TICK:      rdata_o = tick_val;
                W_PROC0:     rdata_o = PROC_ID;
                W_PROC1:     rdata_o = PROC1_VALUE;
                default:     rdata_o = '0;
            endcase
        end
    end

    // R4: a reset request is only ever raised from the unlocked state.
    p_req_needs_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req_o |-> $past(unlocked));

    // R8: the request output is low in the cycle after a reset.
    p_req_low_after_reset_r8: assert property (@(posedge clk)
        !rst_n |=> !sys_rst_req_o);

endmodule

// File: tb/tb_sysctl_regbank.sv
`timescale 1ns/1ps
// tb_sysctl_regbank: three instances, one per trigger variant, share one bus.
// A bench-side model built from the requirements predicts every read.
module tb_sysctl_regbank;

    localparam int LED_W = 8;
    localparam int DIV   = 3;

    localparam logic [31:0] ID0 = 32'h4100_5A0F; // variant 0x100, bit 8
    localparam logic [31:0] ID1 = 32'h3178_0001; // variant 0x178, bit 2
    localparam logic [31:0] ID2 = 32'h0190_0002; // variant 0x190, none
    localparam logic [31:0] PR0 = 32'h1111_0000;
    localparam logic [31:0] PR1 = 32'h2222_0001;
    localparam logic [31:0] PR2 = 32'h3333_0002;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd [3];
    logic [7:0]  led [3];
    logic        req [3];

    always #4 clk = ~clk;

    sysctl_regbank #(.ID_WORD(ID0), .PROC_ID(PR0), .LED_W(LED_W), .TICK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rd[0]), .led_o(led[0]), .sys_rst_req_o(req[0]));
    sysctl_regbank #(.ID_WORD(ID1), .PROC_ID(PR1), .LED_W(LED_W), .TICK_DIV(DIV)) dut_late (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rd[1]), .led_o(led[1]), .sys_rst_req_o(req[1]));
    sysctl_regbank #(.ID_WORD(ID2), .PROC_ID(PR2), .LED_W(LED_W), .TICK_DIV(DIV)) dut_none (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rd[2]), .led_o(led[2]), .sys_rst_req_o(req[2]));

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Model state.
    logic [31:0] m_id [3];
    logic [31:0] m_proc [3];
    int          m_trig [3];
    logic [31:0] m_rstctl [3];
    logic [7:0]  m_led;
    logic [15:0] m_lock;
    logic [31:0] m_cfg0, m_cfg1, m_vflg, m_nvflg;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int i, input int w);
        case (w)
            'h00:    return m_id[i];
            'h02:    return {24'h0, m_led};
            'h08:    return {16'h0, m_lock};
            'h0A:    return m_cfg0;
            'h0B:    return m_cfg1;
            'h0C:    return m_vflg;
            'h0E:    return m_nvflg;
            'h10:    return m_rstctl[i];
            'h11:    return 32'h1;
            'h21:    return m_proc[i];
            'h22:    return 32'hFF00_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input int w);
        case (w)
            'h00, 'h11, 'h21, 'h22: return "R1";
            'h02, 'h0A, 'h0B:       return "R9";
            'h08:                   return "R2";
            'h0C:                   return "R6";
            'h0E:                   return "R7";
            'h10:                   return "R3";
            default:                return "R11";
        endcase
    endfunction

    task automatic model_reset();
        m_led = '0; m_lock = '0; m_cfg0 = '0; m_cfg1 = '0; m_vflg = '0;
        for (int i = 0; i < 3; i++) m_rstctl[i] = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        addr = 12'h05C;
        #1;
        for (int i = 0; i < 3; i++) begin
            chk("R10 tick held in reset", rd[i], 32'h0);
            chk("R8 request low in reset", {31'h0, req[i]}, 32'h0);
        end
        model_reset();
        rst_n = 1'b1;
    endtask

    // Reads one byte address on all instances and compares with the model.
    task automatic rd_chk(input logic [11:0] a, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        for (int i = 0; i < 3; i++) begin
            chk(tag, rd[i], (a[1:0] == 2'b00) ? exp_rd(i, int'(a[11:2])) : 32'h0);
        end
    endtask

    // Writes on the bus, updates the model, checks the request pulse window.
    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        bit exp_req [3];
        bit lock_ok;
        int w;
        w = int'(a[11:2]);
        lock_ok = (m_lock == 16'hA05F);
        for (int i = 0; i < 3; i++) exp_req[i] = 1'b0;
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a[1:0] == 2'b00) begin
            case (w)
                'h02: m_led = d[7:0];
                'h08: m_lock = (d[15:0] == 16'hA05F) ? d[15:0] : {1'b0, d[14:0]};
                'h0A: m_cfg0 = d;
                'h0B: m_cfg1 = d;
                'h0C: m_vflg = m_vflg | d;
                'h0D: m_vflg = m_vflg & ~d;
                'h0E: m_nvflg = m_nvflg | d;
                'h0F: m_nvflg = m_nvflg & ~d;
                'h10: begin
                    for (int i = 0; i < 3; i++) begin
                        if (lock_ok && m_trig[i] >= 0) begin
                            m_rstctl[i] = d;
                            exp_req[i]  = d[m_trig[i]];
                        end
                    end
                end
                default: ;
            endcase
        end
        #1;
        for (int i = 0; i < 3; i++) begin
            chk((m_trig[i] >= 0) ? "R4 request pulse" : "R5 no request",
                {31'h0, req[i]}, {31'h0, exp_req[i]});
        end
        @(negedge clk);
        #1;
        for (int i = 0; i < 3; i++) begin
            chk("R4 request lasts one cycle", {31'h0, req[i]}, 32'h0);
        end
    endtask

    task automatic sweep(input string phase);
        for (int w = 0; w < 1024; w++) begin
            if (w != 'h17) rd_chk(12'(w << 2), tag_of(w));
        end
        $display("sweep %s done", phase);
    endtask

    initial begin
        logic [31:0] t0 [3];
        m_id[0] = ID0; m_id[1] = ID1; m_id[2] = ID2;
        m_proc[0] = PR0; m_proc[1] = PR1; m_proc[2] = PR2;
        m_trig[0] = 8; m_trig[1] = 2; m_trig[2] = -1;
        m_nvflg = '0;
        model_reset();

        do_reset();
        bus_wr(12'h03C, 32'hFFFF_FFFF);          // R7 start from known nv flags
        sweep("R8 reset state");                 // R1, R8, R11

        // R10: 12 edges at divide 3 gives exactly 4 steps.
        @(negedge clk); addr = 12'h05C; #1;
        for (int i = 0; i < 3; i++) t0[i] = rd[i];
        repeat (12) @(negedge clk);
        #1;
        for (int i = 0; i < 3; i++) chk("R10 tick rate", rd[i] - t0[i], 32'd4);

        // R9: LED and configuration words.
        bus_wr(12'h008, 32'hFFFF_FFA5);
        rd_chk(12'h008, "R9 led readback");
        for (int i = 0; i < 3; i++) chk("R9 led_o", {24'h0, led[i]}, 32'hA5);
        bus_wr(12'h028, 32'hDEAD_BEEF);
        bus_wr(12'h02C, 32'h0123_4567);
        rd_chk(12'h028, "R9 cfg0");
        rd_chk(12'h02C, "R9 cfg1");

        // R6: volatile flags.
        bus_wr(12'h030, 32'h0000_0F0F);
        bus_wr(12'h030, 32'h0000_3000);
        rd_chk(12'h030, "R6 set accumulates");
        chk("R6 model", m_vflg, 32'h0000_3F0F);
        bus_wr(12'h034, 32'h0000_0F00);
        rd_chk(12'h030, "R6 clear");

        // R7: non-volatile flags.
        bus_wr(12'h038, 32'h8000_0011);
        bus_wr(12'h03C, 32'h0000_0010);
        rd_chk(12'h038, "R7 set and clear");

        // R3: locked reset-control write is ignored.
        bus_wr(12'h040, 32'h0000_0104);
        rd_chk(12'h040, "R3 locked write ignored");

        // R2: wrong key stored with bit 15 cleared.
        bus_wr(12'h020, 32'h1234_FFFF);
        rd_chk(12'h020, "R2 wrong key");
        bus_wr(12'h040, 32'h0000_0104);
        rd_chk(12'h040, "R3 still locked");
        bus_wr(12'h020, 32'h0000_A05F);
        rd_chk(12'h020, "R2 key stored");

        // R4/R5: trigger bits per variant.
        bus_wr(12'h040, 32'h0000_0104);
        rd_chk(12'h040, "R3 unlocked write stored");
        bus_wr(12'h040, 32'h0000_0100);
        bus_wr(12'h040, 32'h0000_0004);
        bus_wr(12'h040, 32'hFFFF_FEFB);
        rd_chk(12'h040, "R5 absent reads zero");

        // R11: unaligned and unmapped writes change nothing.
        bus_wr(12'h009, 32'h0000_0000);
        rd_chk(12'h009, "R11 unaligned read");
        for (int w = 0; w < 1024; w++) begin
            if (!(w inside {'h02, 'h08, 'h0A, 'h0B, 'h0C, 'h0D, 'h0E, 'h0F, 'h10}))
                bus_wr(12'(w << 2), 32'hFFFF_FFFF);
        end
        sweep("R11 after unmapped writes");

        // R7/R8: reset clears volatile state but keeps non-volatile flags.
        bus_wr(12'h030, 32'h0000_00FF);
        do_reset();
        sweep("R8 second reset");
        rd_chk(12'h038, "R7 survives reset");
        for (int i = 0; i < 3; i++) chk("R8 led_o cleared", {24'h0, led[i]}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule